// File: doc/BRIEF.md
# Reserved-Pool Bad Block Remapper

This block sits between a flash translation layer and the NAND command path and turns a logical block address into the physical block that actually holds the data. The physical array is split into a user area, which the translation layer may address, and a reserved pool at the top of the array, set by a start block and a block count. Blocks in the reserved pool are only used as replacements. They can also hold the saved table.

The remapper keeps one record per reserved block, naming the user block it currently stands in for. A lookup returns the replacement block when the logical block has been remapped. Otherwise it returns the logical address unchanged, so the requester always uses the same logical address. Factory bad blocks found by the start-up scan are fed in before normal traffic begins. User blocks from the scan are remapped. Reserved blocks from the scan are withdrawn from the pool. When the device reports a program or erase failure on a logical block, the remapper takes the lowest free reserved block, records the mapping and raises a one-cycle copy request naming the source and destination blocks. The data copy, the status polling and the saving of the table to flash are done elsewhere.

Top module: `bbm_remap`

## Requirements
- R1: After reset no block is remapped, and `overflow_o`, `lookup_valid_o`, `copy_req_o` and `fail_refused_o` are all low.
- R2: A lookup presented while `lookup_valid_i` is high returns its result with `lookup_valid_o` high exactly one cycle later. A user-area block with no mapping returns its own address with `lookup_remapped_o` low. Lookups may be issued back to back.
- R3: A lookup of a remapped user block returns the physical address of its replacement block, with `lookup_remapped_o` high. The lookup sees every update committed on an earlier clock edge.
- R4: A failure report (`fail_valid_i`) on an unmapped user block allocates the lowest-numbered reserved block that is neither in use nor marked bad. Reserved block k has physical address RSV_START+k. One cycle after the report, `copy_req_o` pulses for one cycle with `copy_src_o` set to the logical block and `copy_dst_o` set to the new block.
- R5: A start-up scan entry (`scan_valid_i`) naming a user-area block remaps that block exactly as R4 does, but raises no copy request.
- R6: A scan entry naming a block inside the reserved pool marks that block bad, and allocation skips it from then on.
- R7: A failure report on a user block that is already remapped moves it to a newly allocated reserved block. `copy_src_o` is the old replacement block. The old replacement is marked bad and is never handed out again.
- R8: When a failure or scan entry needs a reserved block and none is free, the mapping is left unchanged and no copy request is raised. `fail_refused_o` pulses one cycle later, and `overflow_o` goes high and stays high until reset.
- R9: A lookup of an address at or above RSV_START returns the address unchanged, with `lookup_oob_o` high and `lookup_remapped_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request strobe |
| lookup_lba_i | input | BLK_W | Logical block to translate |
| lookup_valid_o | output | 1 | Lookup result valid, one cycle after the request |
| lookup_pba_o | output | BLK_W | Physical block for the request |
| lookup_remapped_o | output | 1 | Result is a replacement block |
| lookup_oob_o | output | 1 | Requested address lies outside the user area |
| fail_valid_i | input | 1 | Program or erase failure report strobe |
| fail_lba_i | input | BLK_W | Logical block whose physical block failed |
| scan_valid_i | input | 1 | Factory bad block entry from the start-up scan (takes precedence over a failure report in the same cycle) |
| scan_pba_i | input | BLK_W | Physical block found bad by the scan |
| copy_req_o | output | 1 | One-cycle request to copy a failed block |
| copy_src_o | output | BLK_W | Physical block to copy from |
| copy_dst_o | output | BLK_W | Replacement block to copy to |
| fail_refused_o | output | 1 | One-cycle pulse: a remap was refused because the pool is empty |
| overflow_o | output | 1 | Sticky flag: the reserved pool is exhausted |

## Verification
On every cycle, the assertions check the one-cycle lookup latency and the unchanged address returned for a block with no mapping. They also check that at most one reserved block claims any logical address, that a block is only allocated when it is free, that a replacement and a copy destination always lie inside the pool, and that the overflow flag never falls. The allocation order, the skipping of factory-bad and retired reserved blocks, the move of an already-remapped block to a fresh one, and the refusal once the pool runs dry can only be shown by the bench's scenarios. The bench compares each lookup result and each copy request against addresses worked out from the requirements.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [1:0] {
    EV_NONE,
    EV_SCAN_USER,
    EV_SCAN_RSV,
    EV_FAIL
  } bbm_ev_e;

  // pool size: 2% of the array, at least two blocks
  function automatic int rsv_default(input int n);
    return (n / 50 < 2) ? 2 : n / 50;
  endfunction
endpackage

// File: rtl/bbm_match.sv
module bbm_match #(
  parameter int N  = 20,
  parameter int AW = 10,
  parameter int IW = 5
) (
  input  logic [N-1:0]    vld_i,
  input  logic [N*AW-1:0] keys_i,
  input  logic [AW-1:0]   key_i,
  output logic [N-1:0]    hit_vec_o,
  output logic            hit_o,
  output logic [IW-1:0]   idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = vld_i[g] && (keys_i[g*AW +: AW] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec_o[i]) idx_o = idx_o | IW'(i);
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/bbm_alloc.sv
module bbm_alloc #(
  parameter int N  = 20,
  parameter int IW = 5
) (
  input  logic [N-1:0]  busy_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest free slot wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bbm_table.sv
module bbm_table #(
  parameter int N  = 20,
  parameter int AW = 10,
  parameter int IW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_en_i,
  input  logic [IW-1:0]   alloc_idx_i,
  input  logic [AW-1:0]   alloc_owner_i,
  input  logic            retire_en_i,
  input  logic [IW-1:0]   retire_idx_i,
  input  logic            mark_en_i,
  input  logic [IW-1:0]   mark_idx_i,
  output logic [N-1:0]    owner_vld_o,
  output logic [N*AW-1:0] owner_o,
  output logic [N-1:0]    busy_o
);
  logic [N-1:0]  owner_vld_q;
  logic [N-1:0]  used_q;
  logic [N-1:0]  bad_q;
  logic [AW-1:0] owner_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_vld_q <= '0;
      used_q      <= '0;
      bad_q       <= '0;
      for (int i = 0; i < N; i++) owner_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_en_i && alloc_idx_i == IW'(i)) begin
          used_q[i]      <= 1'b1;
          owner_vld_q[i] <= 1'b1;
          owner_q[i]     <= alloc_owner_i;
        end
        if (retire_en_i && retire_idx_i == IW'(i)) begin
          owner_vld_q[i] <= 1'b0;
          bad_q[i]       <= 1'b1;
        end
        // scan marks only blocks not yet handed out
        if (mark_en_i && mark_idx_i == IW'(i) && !used_q[i])
          bad_q[i] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign owner_o[g*AW +: AW] = owner_q[g];
  end
  assign owner_vld_o = owner_vld_q;
  assign busy_o      = used_q | bad_q;

  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> !busy_o[alloc_idx_i]); // R4
  AST_RETIRE_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_en_i |-> owner_vld_q[retire_idx_i]); // R7
  AST_RETIRED_STAYS_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_en_i |=> busy_o[$past(retire_idx_i)] && !owner_vld_o[$past(retire_idx_i)]); // R7
endmodule

// File: rtl/bbm_remap.sv
module bbm_remap
  import bbm_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int RSV_COUNT  = rsv_default(NUM_BLOCKS),
  parameter int RSV_START  = NUM_BLOCKS - RSV_COUNT,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int SLOT_W    = $clog2(RSV_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [BLK_W-1:0] lookup_lba_i,
  output logic             lookup_valid_o,
  output logic [BLK_W-1:0] lookup_pba_o,
  output logic             lookup_remapped_o,
  output logic             lookup_oob_o,
  input  logic             fail_valid_i,
  input  logic [BLK_W-1:0] fail_lba_i,
  input  logic             scan_valid_i,
  input  logic [BLK_W-1:0] scan_pba_i,
  output logic             copy_req_o,
  output logic [BLK_W-1:0] copy_src_o,
  output logic [BLK_W-1:0] copy_dst_o,
  output logic             fail_refused_o,
  output logic             overflow_o
);
  localparam logic [BLK_W-1:0] RSV_BASE = BLK_W'(RSV_START);
  localparam logic [BLK_W:0]   RSV_END  = (BLK_W + 1)'(RSV_START + RSV_COUNT);

  logic [RSV_COUNT-1:0]       owner_vld;
  logic [RSV_COUNT*BLK_W-1:0] owner;
  logic [RSV_COUNT-1:0]       busy;
  logic [RSV_COUNT-1:0]       l_hit_vec, u_hit_vec;
  logic                       l_hit, u_hit;
  logic [SLOT_W-1:0]          l_idx, u_idx, a_idx;
  logic                       a_found;

  // event decode
  bbm_ev_e          ev;
  logic [BLK_W-1:0] ev_lba;
  logic             scan_in_rsv;

  assign scan_in_rsv = (scan_pba_i >= RSV_BASE) && ({1'b0, scan_pba_i} < RSV_END);

  always_comb begin
    ev     = EV_NONE;
    ev_lba = fail_lba_i;
    if (scan_valid_i) begin
      ev_lba = scan_pba_i;
      if (scan_pba_i < RSV_BASE) ev = EV_SCAN_USER;
      else if (scan_in_rsv)      ev = EV_SCAN_RSV;
    end else if (fail_valid_i && fail_lba_i < RSV_BASE) begin
      ev = EV_FAIL;
    end
  end

  logic needs_blk, do_alloc, do_refuse;
  assign needs_blk = (ev == EV_SCAN_USER) || (ev == EV_FAIL);
  assign do_alloc  = needs_blk && a_found;
  assign do_refuse = needs_blk && !a_found;

  bbm_match #(.N(RSV_COUNT), .AW(BLK_W), .IW(SLOT_W)) u_lkp_match (
    .vld_i(owner_vld), .keys_i(owner), .key_i(lookup_lba_i),
    .hit_vec_o(l_hit_vec), .hit_o(l_hit), .idx_o(l_idx)
  );

  bbm_match #(.N(RSV_COUNT), .AW(BLK_W), .IW(SLOT_W)) u_upd_match (
    .vld_i(owner_vld), .keys_i(owner), .key_i(ev_lba),
    .hit_vec_o(u_hit_vec), .hit_o(u_hit), .idx_o(u_idx)
  );

  bbm_alloc #(.N(RSV_COUNT), .IW(SLOT_W)) u_alloc (
    .busy_i(busy), .found_o(a_found), .idx_o(a_idx)
  );

  bbm_table #(.N(RSV_COUNT), .AW(BLK_W), .IW(SLOT_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (do_alloc),
    .alloc_idx_i  (a_idx),
    .alloc_owner_i(ev_lba),
    .retire_en_i  (do_alloc && u_hit),
    .retire_idx_i (u_idx),
    .mark_en_i    (ev == EV_SCAN_RSV),
    .mark_idx_i   (SLOT_W'(scan_pba_i - RSV_BASE)),
    .owner_vld_o  (owner_vld),
    .owner_o      (owner),
    .busy_o       (busy)
  );

  // lookup stage
  logic lkp_oob;
  assign lkp_oob = lookup_lba_i >= RSV_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lookup_valid_o    <= 1'b0;
      lookup_pba_o      <= '0;
      lookup_remapped_o <= 1'b0;
      lookup_oob_o      <= 1'b0;
    end else begin
      lookup_valid_o    <= lookup_valid_i;
      lookup_remapped_o <= lookup_valid_i && l_hit && !lkp_oob;
      lookup_oob_o      <= lookup_valid_i && lkp_oob;
      if (lookup_valid_i)
        lookup_pba_o <= (l_hit && !lkp_oob) ? RSV_BASE + BLK_W'(l_idx) : lookup_lba_i;
    end
  end

  // copy request and pool status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      copy_req_o     <= 1'b0;
      copy_src_o     <= '0;
      copy_dst_o     <= '0;
      fail_refused_o <= 1'b0;
      overflow_o     <= 1'b0;
    end else begin
      copy_req_o     <= do_alloc && (ev == EV_FAIL);
      fail_refused_o <= do_refuse;
      overflow_o     <= overflow_o | do_refuse;
      if (do_alloc && ev == EV_FAIL) begin
        copy_src_o <= u_hit ? RSV_BASE + BLK_W'(u_idx) : ev_lba;
        copy_dst_o <= RSV_BASE + BLK_W'(a_idx);
      end
    end
  end

  AST_LKP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> lookup_valid_o); // R2
  AST_GOOD_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> (lookup_remapped_o || lookup_pba_o == $past(lookup_lba_i))); // R2
  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(l_hit_vec)); // R3
  AST_REMAP_IN_POOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_remapped_o |-> (lookup_pba_o >= RSV_BASE)); // R3
  AST_COPY_DST_POOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_req_o |-> (copy_dst_o >= RSV_BASE && copy_dst_o != copy_src_o)); // R4
  AST_NO_OVERFLOW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R8
  AST_REFUSE_NO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_refused_o |-> (!copy_req_o && overflow_o)); // R8
  AST_OOB_NOT_REMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_oob_o |-> !lookup_remapped_o); // R9
endmodule

// File: tb/sim_bbm_remap.sv
module sim_bbm_remap;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          lookup_valid_i = 1'b0;
  logic [BW-1:0] lookup_lba_i = '0;
  logic          lookup_valid_o, lookup_remapped_o, lookup_oob_o;
  logic [BW-1:0] lookup_pba_o;
  logic          fail_valid_i = 1'b0;
  logic [BW-1:0] fail_lba_i = '0;
  logic          scan_valid_i = 1'b0;
  logic [BW-1:0] scan_pba_i = '0;
  logic          copy_req_o, fail_refused_o, overflow_o;
  logic [BW-1:0] copy_src_o, copy_dst_o;

  bbm_remap u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lookup_valid_i), .lookup_lba_i(lookup_lba_i),
    .lookup_valid_o(lookup_valid_o), .lookup_pba_o(lookup_pba_o),
    .lookup_remapped_o(lookup_remapped_o), .lookup_oob_o(lookup_oob_o),
    .fail_valid_i(fail_valid_i), .fail_lba_i(fail_lba_i),
    .scan_valid_i(scan_valid_i), .scan_pba_i(scan_pba_i),
    .copy_req_o(copy_req_o), .copy_src_o(copy_src_o), .copy_dst_o(copy_dst_o),
    .fail_refused_o(fail_refused_o), .overflow_o(overflow_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  // scoreboard queues
  int    q_pba[$];
  int    q_rm[$];
  int    q_oob[$];
  string q_ltag[$];
  int    q_src[$];
  int    q_dst[$];
  string q_ctag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lookup_valid_o) begin
        if (q_pba.size() == 0) chk(1'b0, "R2 unexpected lookup result", 1, 0);
        else begin
          string t;
          int p, r, o;
          p = q_pba.pop_front(); r = q_rm.pop_front(); o = q_oob.pop_front();
          t = q_ltag.pop_front();
          chk(int'(lookup_pba_o) == p, {t, " pba"}, int'(lookup_pba_o), p);
          chk(int'(lookup_remapped_o) == r, {t, " remapped"}, int'(lookup_remapped_o), r);
          chk(int'(lookup_oob_o) == o, {t, " oob"}, int'(lookup_oob_o), o);
        end
      end
      if (copy_req_o) begin
        if (q_src.size() == 0) chk(1'b0, "R5/R8 unexpected copy request", 1, 0);
        else begin
          string t;
          int s, d;
          s = q_src.pop_front(); d = q_dst.pop_front(); t = q_ctag.pop_front();
          chk(int'(copy_src_o) == s, {t, " copy src"}, int'(copy_src_o), s);
          chk(int'(copy_dst_o) == d, {t, " copy dst"}, int'(copy_dst_o), d);
        end
      end
    end
  end

  task automatic lkp(input int lba, input int pba, input int rm, input int oob, input string tag);
    @(negedge clk);
    q_pba.push_back(pba); q_rm.push_back(rm); q_oob.push_back(oob); q_ltag.push_back(tag);
    lookup_valid_i = 1'b1;
    lookup_lba_i   = BW'(lba);
    @(negedge clk);
    lookup_valid_i = 1'b0;
  endtask

  task automatic fail_rep(input int lba, input bit refuse, input int src, input int dst, input string tag);
    @(negedge clk);
    if (!refuse) begin
      q_src.push_back(src); q_dst.push_back(dst); q_ctag.push_back(tag);
    end
    fail_valid_i = 1'b1;
    fail_lba_i   = BW'(lba);
    @(negedge clk);
    fail_valid_i = 1'b0;
    chk(fail_refused_o == refuse, {tag, " refused"}, int'(fail_refused_o), int'(refuse));
  endtask

  task automatic scan(input int pba, input string tag);
    @(negedge clk);
    scan_valid_i = 1'b1;
    scan_pba_i   = BW'(pba);
    @(negedge clk);
    scan_valid_i = 1'b0;
    chk(copy_req_o == 1'b0, {tag, " no copy on scan"}, int'(copy_req_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(overflow_o == 1'b0, "R1 overflow", int'(overflow_o), 0);
    chk(lookup_valid_o == 1'b0, "R1 lookup valid", int'(lookup_valid_o), 0);
    chk(copy_req_o == 1'b0, "R1 copy req", int'(copy_req_o), 0);
    chk(fail_refused_o == 1'b0, "R1 refused", int'(fail_refused_o), 0);
    rst_n = 1'b1;
    lkp(7, 7, 0, 0, "R1 no mapping after reset");

    // R2 pass-through, back to back
    @(negedge clk);
    q_pba.push_back(5); q_rm.push_back(0); q_oob.push_back(0); q_ltag.push_back("R2 b2b first");
    lookup_valid_i = 1'b1; lookup_lba_i = 10'd5;
    @(negedge clk);
    q_pba.push_back(500); q_rm.push_back(0); q_oob.push_back(0); q_ltag.push_back("R2 b2b second");
    lookup_lba_i = 10'd500;
    @(negedge clk);
    lookup_valid_i = 1'b0;

    // R6 factory-bad reserved block, R5 factory-bad user block
    scan(1004, "R6");
    scan(10, "R5");
    lkp(10, 1005, 1, 0, "R5 R3 scan remap skips bad 1004");

    // R9 out of user area
    lkp(1004, 1004, 0, 1, "R9 pool start");
    lkp(1023, 1023, 0, 1, "R9 pool end");

    // R4 failure on unmapped block
    fail_rep(20, 1'b0, 20, 1006, "R4");
    lkp(20, 1006, 1, 0, "R3 after fail");

    // R7 failure on remapped block
    fail_rep(10, 1'b0, 1005, 1007, "R7");
    lkp(10, 1007, 1, 0, "R7 moved");

    // fill the pool: 1008..1023
    for (int i = 0; i < 16; i++) fail_rep(100 + i, 1'b0, 100 + i, 1008 + i, "R4 fill");
    lkp(115, 1023, 1, 0, "R4 last slot");
    chk(overflow_o == 1'b0, "R8 no overflow yet", int'(overflow_o), 0);

    // R8 exhaustion
    fail_rep(200, 1'b1, 0, 0, "R8");
    chk(overflow_o == 1'b1, "R8 overflow set", int'(overflow_o), 1);
    lkp(200, 200, 0, 0, "R8 unmapped after refusal");
    fail_rep(10, 1'b1, 0, 0, "R8 remapped refused");
    lkp(10, 1007, 1, 0, "R8 mapping kept");
    repeat (4) @(negedge clk);
    chk(overflow_o == 1'b1, "R8 overflow sticky", int'(overflow_o), 1);

    repeat (2) @(negedge clk);
    chk(q_pba.size() == 0, "R2 lookup results outstanding", q_pba.size(), 0);
    chk(q_src.size() == 0, "R4 copy requests outstanding", q_src.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule